// File: doc/BRIEF.md
# Banked Stack Pointer Unit with Region Limits

This block keeps two 32-bit stack pointers, a main pointer and a process pointer, and generates memory addresses for a full-descending stack of 32-bit words. The execution mode and a select bit decide which pointer a command works on. A push moves the pointer down one word and then stores at the new address. A pop reads at the current address and then moves the pointer up one word. A command can name several words. The unit then performs one word per cycle on consecutive cycles and raises `busy` for the whole run.

Every address the unit presents is compared against a programmable lower limit and a programmable upper limit. A violation sets a sticky flag. The access itself still goes out to memory. A direct write port can load either pointer. While reset is held, the main pointer takes its value from a boot-word input.

Top module: `stack_ptr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the main pointer loads `boot_word` with bits [1:0] cleared, the process pointer loads 0, and both flags clear. After release, `busy` is 0, and with `handler_mode`=0 and `ctl_psel`=0 the `sp_active` output shows the main pointer.
- R2: A push starts when `cmd_push`=1 and the unit is idle. If `cmd_pop` is also 1, the push takes priority. In that same cycle `mem_we`=1 and `mem_addr` equals the chosen pointer minus 4. At the next edge the pointer becomes that address.
- R3: A pop starts when `cmd_pop`=1, `cmd_push`=0 and the unit is idle. In that same cycle `mem_re`=1 and `mem_addr` equals the chosen pointer. At the next edge the pointer increases by 4.
- R4: When `handler_mode`=1 the main pointer is chosen. When `handler_mode`=0 the process pointer is chosen if `ctl_psel`=1, and the main pointer if `ctl_psel`=0.
- R5: A command with `cmd_count`=k (k≥2) runs k word operations on k consecutive cycles, with `busy`=1 in each of them. A value of 0 or 1 gives a single word with `busy`=0. The direction and the pointer are fixed when the command is accepted. Commands, mode and select changes during `busy` have no effect.
- R6: Any access whose address is below `lim_lo` sets `ovf_flag` at the next edge. The strobe and address are still driven for that access.
- R7: Any access whose address is at or above `lim_hi` sets `unf_flag` at the next edge.
- R8: A set flag stays set until a cycle with `flag_clr`=1 clears it. If a new violation happens in the same cycle as the clear, the set wins.
- R9: When `wr_en`=1, the pointer named by `wr_sel` (0 = main, 1 = process) loads `wr_data` with bits [1:0] cleared. This write takes precedence over a stack update of the same pointer in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_word | input | AW | Initial main pointer value, sampled during reset |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| ctl_psel | input | 1 | In thread mode, 1 selects the process pointer |
| cmd_push | input | 1 | Push command |
| cmd_pop | input | 1 | Pop command |
| cmd_count | input | CW | Number of words in the command |
| wr_en | input | 1 | Direct pointer write enable |
| wr_sel | input | 1 | Write target: 0 main, 1 process |
| wr_data | input | AW | Direct write value |
| lim_lo | input | AW | Lowest legal address |
| lim_hi | input | AW | First illegal address above the stack |
| flag_clr | input | 1 | Clears both violation flags |
| mem_addr | output | AW | Word address of the current access |
| mem_we | output | 1 | Store strobe (push) |
| mem_re | output | 1 | Load strobe (pop) |
| busy | output | 1 | Multi-word command in progress |
| sp_main | output | AW | Main pointer |
| sp_proc | output | AW | Process pointer |
| sp_active | output | AW | Pointer chosen by the present mode and select bit |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The in-line properties assume that the limits stay steady across an access. They also assume that a pointer does not wrap around address zero within a run, so that the strobe and pointer relations hold at every edge. The stimulus keeps the pointers in the middle of a region well away from zero and the top of memory. It changes the limits only in idle cycles and drives the write port only in cycles whose outcome the bench predicts. The mode and select inputs are toggled during a run only to show that they have no effect then.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] boot_word,
  input  logic          handler_mode,
  input  logic          ctl_psel,
  input  logic          cmd_push,
  input  logic          cmd_pop,
  input  logic [CW-1:0] cmd_count,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] lim_lo,
  input  logic [AW-1:0] lim_hi,
  input  logic          flag_clr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic          busy,
  output logic [AW-1:0] sp_main,
  output logic [AW-1:0] sp_proc,
  output logic [AW-1:0] sp_active,
  output logic          ovf_flag,
  output logic          unf_flag
);
  localparam logic [AW-1:0] WORD  = AW'(4);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] rem;
  logic          hold_push, hold_proc;

  wire idle      = (rem == '0);
  wire take      = idle & (cmd_push | cmd_pop);
  wire pick_proc = ~handler_mode & ctl_psel;
  wire go        = take | ~idle;
  wire dir_push  = idle ? cmd_push  : hold_push;
  wire use_proc  = idle ? pick_proc : hold_proc;

  wire [AW-1:0] cur = use_proc ? sp_proc : sp_main;
  wire [AW-1:0] nxt = dir_push ? cur - WORD : cur + WORD;

  assign mem_addr  = dir_push ? nxt : cur;
  assign mem_we    = go & dir_push;
  assign mem_re    = go & ~dir_push;
  assign busy      = ~idle | (take & (cmd_count > ONE));
  assign sp_active = pick_proc ? sp_proc : sp_main;

  wire lo_hit = go & (mem_addr < lim_lo);
  wire hi_hit = go & (mem_addr >= lim_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem       <= '0;
      hold_push <= 1'b0;
      hold_proc <= 1'b0;
    end else if (take) begin
      rem       <= (cmd_count == '0) ? '0 : cmd_count - ONE;
      hold_push <= cmd_push;
      hold_proc <= pick_proc;
    end else if (!idle) begin
      rem <= rem - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_main <= boot_word & ALIGN;
      sp_proc <= '0;
    end else begin
      if (wr_en && !wr_sel)      sp_main <= wr_data & ALIGN;
      else if (go && !use_proc)  sp_main <= nxt;
      if (wr_en && wr_sel)       sp_proc <= wr_data & ALIGN;
      else if (go && use_proc)   sp_proc <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      ovf_flag <= lo_hit | (ovf_flag & ~flag_clr);
      unf_flag <= hi_hit | (unf_flag & ~flag_clr);
    end
  end

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !use_proc && !(wr_en && !wr_sel) |=> sp_main == $past(sp_main) - WORD);

  // R3
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && use_proc && !(wr_en && wr_sel) |=> sp_proc == $past(sp_proc) + WORD);

  // R4
  handler_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && handler_mode && !wr_en |=> sp_proc == $past(sp_proc));

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && (mem_addr < lim_lo) |=> ovf_flag);

  // R7
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && (mem_addr >= lim_hi) |=> unf_flag);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr |=> ovf_flag);

  // R9
  wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> sp_main[1:0] == 2'b00);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] boot_word = 32'h2000_1003;
  logic handler_mode = 0, ctl_psel = 0, cmd_push = 0, cmd_pop = 0;
  logic [3:0] cmd_count = 4'd1;
  logic wr_en = 0, wr_sel = 0, flag_clr = 0;
  logic [31:0] wr_data = '0, lim_lo = '0, lim_hi = 32'hFFFF_FFFF;
  logic [31:0] mem_addr, sp_main, sp_proc, sp_active;
  logic mem_we, mem_re, busy, ovf_flag, unf_flag;
  int total = 0, bad = 0;
  bit done = 0;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .boot_word(boot_word), .handler_mode(handler_mode),
    .ctl_psel(ctl_psel), .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_count(cmd_count),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .flag_clr(flag_clr), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .busy(busy), .sp_main(sp_main), .sp_proc(sp_proc), .sp_active(sp_active),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  always #(CLK_NS/2) clk = ~clk;

  // {handler, psel, push, pop, expected address, expected pointer after}
  localparam logic [67:0] VEC [8] = '{
    {4'b0010, 32'h2000_0FFC, 32'h2000_0FFC},
    {4'b0110, 32'h2000_07FC, 32'h2000_07FC},
    {4'b1110, 32'h2000_0FF8, 32'h2000_0FF8},
    {4'b1001, 32'h2000_0FF8, 32'h2000_0FFC},
    {4'b0101, 32'h2000_07FC, 32'h2000_0800},
    {4'b0001, 32'h2000_0FFC, 32'h2000_1000},
    {4'b0011, 32'h2000_0FFC, 32'h2000_0FFC},
    {4'b0001, 32'h2000_0FFC, 32'h2000_1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op1(input string req, input logic h, input logic p, input logic pu,
                     input logic po, input logic [3:0] cnt,
                     input logic [31:0] eaddr, input logic [31:0] eafter);
    @(negedge clk);
    handler_mode = h; ctl_psel = p; cmd_push = pu; cmd_pop = po; cmd_count = cnt;
    #1;
    chk(req, mem_addr, eaddr);
    chk(req, {30'd0, mem_we, mem_re}, pu ? 32'd2 : 32'd1);
    chk(req, {31'd0, busy}, 32'd0);
    @(negedge clk);
    cmd_push = 0; cmd_pop = 0; cmd_count = 4'd1;
    #1;
    chk(req, sp_active, eafter);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 main", sp_main, 32'h2000_1000);
    chk("R1 proc", sp_proc, 32'h0);
    chk("R1 active", sp_active, 32'h2000_1000);
    chk("R1 flags", {30'd0, ovf_flag, unf_flag}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);

    // R9 process pointer load with low bits cleared
    @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = 32'h2000_0803;
    @(negedge clk); wr_en = 0; #1;
    chk("R9 align", sp_proc, 32'h2000_0800);

    // R2 R3 R4 table walk
    foreach (VEC[i])
      op1($sformatf("R4 vec%0d", i), VEC[i][67], VEC[i][66], VEC[i][65], VEC[i][64],
          4'd1, VEC[i][63:32], VEC[i][31:0]);
    chk("R4 proc untouched", sp_proc, 32'h2000_0800);

    // R9 write beats a push of the same pointer
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 32'h2000_1001;
    handler_mode = 0; ctl_psel = 0; cmd_push = 1;
    @(negedge clk); wr_en = 0; cmd_push = 0; #1;
    chk("R9 priority", sp_main, 32'h2000_1000);

    // R5 count 0 acts as one word
    op1("R5 count0", 0, 0, 1, 0, 4'd0, 32'h2000_0FFC, 32'h2000_0FFC);
    op1("R5 count0 back", 0, 0, 0, 1, 4'd1, 32'h2000_0FFC, 32'h2000_1000);

    // R5 three-word push, other inputs changed while busy
    @(negedge clk); cmd_push = 1; cmd_count = 4'd3; #1;
    chk("R5 w1 addr", mem_addr, 32'h2000_0FFC);
    chk("R5 w1 busy", {31'd0, busy}, 32'd1);
    @(negedge clk); cmd_push = 0; cmd_pop = 1; ctl_psel = 1; #1;
    chk("R5 w2 addr", mem_addr, 32'h2000_0FF8);
    chk("R5 w2 we", {30'd0, mem_we, busy}, 32'd3);
    @(negedge clk); #1;
    chk("R5 w3 addr", mem_addr, 32'h2000_0FF4);
    chk("R5 w3 we", {30'd0, mem_we, busy}, 32'd3);
    @(negedge clk); cmd_pop = 0; ctl_psel = 0; cmd_count = 4'd1; #1;
    chk("R5 end busy", {31'd0, busy}, 32'd0);
    chk("R5 main", sp_main, 32'h2000_0FF4);
    chk("R5 proc", sp_proc, 32'h2000_0800);

    // R5 three-word pop
    @(negedge clk); cmd_pop = 1; cmd_count = 4'd3; #1;
    chk("R5 p1", mem_addr, 32'h2000_0FF4);
    @(negedge clk); cmd_pop = 0; #1;
    chk("R5 p2", mem_addr, 32'h2000_0FF8);
    chk("R5 p2 re", {30'd0, mem_re, busy}, 32'd3);
    @(negedge clk); #1;
    chk("R5 p3", mem_addr, 32'h2000_0FFC);
    @(negedge clk); cmd_count = 4'd1; #1;
    chk("R5 pop main", sp_main, 32'h2000_1000);

    // R6 overflow, R8 sticky and clear
    @(negedge clk); lim_lo = 32'h2000_0FFC;
    op1("R6 edge", 0, 0, 1, 0, 4'd1, 32'h2000_0FFC, 32'h2000_0FFC);
    chk("R6 none", {31'd0, ovf_flag}, 32'd0);
    op1("R6 below", 0, 0, 1, 0, 4'd1, 32'h2000_0FF8, 32'h2000_0FF8);
    chk("R6 set", {31'd0, ovf_flag}, 32'd1);
    @(negedge clk); #1;
    chk("R8 sticky", {31'd0, ovf_flag}, 32'd1);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0; #1;
    chk("R8 clear", {31'd0, ovf_flag}, 32'd0);

    // R7 underflow
    @(negedge clk); lim_lo = '0; lim_hi = 32'h2000_1000;
    op1("R7 a", 0, 0, 0, 1, 4'd1, 32'h2000_0FF8, 32'h2000_0FFC);
    op1("R7 b", 0, 0, 0, 1, 4'd1, 32'h2000_0FFC, 32'h2000_1000);
    chk("R7 none", {31'd0, unf_flag}, 32'd0);
    op1("R7 top", 0, 0, 0, 1, 4'd1, 32'h2000_1000, 32'h2000_1004);
    chk("R7 set", {31'd0, unf_flag}, 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule